// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block provides two independent 32-bit up-counting timers reached through a processor auxiliary-register port. Each timer exposes three registers: a live count, a control word and a limit. A timer advances by one per clock from whatever count software last wrote. When it advances while the count equals the limit, the count returns to zero and the timer has expired. Counting then carries on, so a timer repeats with a period of limit + 1 clocks without being reprogrammed. Setting the limit to all ones turns a timer into a free-running wrapping counter.

Each timer drives one level interrupt. A small state machine per timer tracks it, with three states:
- IRQ_IDLE: interrupt not enabled.
- IRQ_ARMED: enabled and waiting for an expiry.
- IRQ_FIRED: the interrupt output is high.

The transitions are:
- arm: a control write with bit 0 set moves IDLE, ARMED or FIRED to ARMED.
- disarm: a control write with bit 0 clear moves any state to IDLE.
- fire: an expiry while ARMED, with no control write in that cycle, moves ARMED to FIRED.

Every other case holds the state. Any control write therefore acknowledges a pending interrupt, and the value of bit 0 in that write decides whether the timer is re-armed. A second control bit makes a timer stand still while the CPU-halted input is high.

Top module: `dual_interval_timer`

## Requirements
- R1: While reset is asserted and after it is released, every count, control and limit register reads 0 and both interrupt outputs are low.
- R2: The address map is as follows, and any other address reads 0 and a write to it changes nothing:
  - timer 0: count at 0x021, control at 0x022, limit at 0x023.
  - timer 1: count at 0x100, control at 0x101, limit at 0x102.
- R3: Count and limit read back as full 32-bit values. Control reads back {30'b0, hold_bit, enable_bit}: bit 0 is the interrupt enable and bit 1 is hold-when-halted.
- R4: On each clock where a timer advances, its count goes to count + 1. If the count equals the limit on that clock, the count goes to 0 instead; this is an expiry.
- R5: With the limit at 0xFFFFFFFF the count passes through 0xFFFFFFFF and wraps to 0, then keeps counting.
- R6: With control bit 1 set, the count does not change while the CPU-halted input is high. With bit 1 clear, the timer advances on every clock regardless of that input.
- R7: An expiry while the enable is set drives that timer's interrupt high from the next clock. The interrupt stays high until that timer's control register is written.
- R8: Any write to a control register drives that timer's interrupt low on the next clock, whatever value is written. The written bit 0 decides whether later expiries raise the interrupt (1) or not (0).
- R9: A control write in the same clock as an expiry wins: the interrupt is low afterwards.
- R10: A count write overrides advancing in that clock: the count takes the written value, that clock is not an expiry, and counting resumes from the written value.
- R11: The two timers are independent. Writes to one timer, its expiries and its interrupt leave the other timer's registers and interrupt unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write enable, one write per clock |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cpu_halted | input | 1 | High while the CPU is halted |
| timer_irq | output | 2 | Level interrupt, bit 0 for timer 0, bit 1 for timer 1 |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 12-bit address and the base addresses 0x021 and 0x100. With these defaults, wrapping past 0xFFFFFFFF is reached in a few clocks by writing a count just below the top. Random traffic keeps both limits below 12, so expiries, write-versus-expiry collisions and halted stretches occur hundreds of times on both timers within a few thousand clocks.

// File: rtl/dit_pkg.sv
package dit_pkg;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_ARMED = 2'd1,
        IRQ_FIRED = 2'd2
    } irq_state_e;

    localparam int unsigned CTL_EN_BIT   = 0;
    localparam int unsigned CTL_HOLD_BIT = 1;
    localparam int unsigned CTL_W        = 2;
    localparam int unsigned REGS_PER_TMR = 3;

endpackage

// File: rtl/dit_decode.sv
module dit_decode #(
    parameter int unsigned         ADDR_W = 12,
    parameter logic [ADDR_W-1:0]   BASE   = 12'h021
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              we,
    output logic                              cnt_we,
    output logic                              ctl_we,
    output logic                              lim_we,
    output logic [dit_pkg::REGS_PER_TMR-1:0]  sel
);
    localparam logic [ADDR_W-1:0] ONE   = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] A_CNT = BASE;
    localparam logic [ADDR_W-1:0] A_CTL = BASE + ONE;
    localparam logic [ADDR_W-1:0] A_LIM = BASE + ONE + ONE;

    always_comb begin
        sel    = '0;
        sel[0] = (addr == A_CNT);
        sel[1] = (addr == A_CTL);
        sel[2] = (addr == A_LIM);
    end

    assign cnt_we = we && sel[0];
    assign ctl_we = we && sel[1];
    assign lim_we = we && sel[2];

endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted,
    input  logic              cnt_we,
    input  logic              ctl_we,
    input  logic              lim_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] limit,
    output logic              hold_en,
    output logic              expiry
);
    logic tick;
    logic at_limit;

    assign tick     = !(hold_en && halted);
    assign at_limit = (count == limit);
    assign expiry   = tick && !cnt_we && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cnt_we) begin
            count <= wdata;
        end else if (tick) begin
            count <= at_limit ? '0 : count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit <= '0;
        end else if (lim_we) begin
            limit <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_en <= 1'b0;
        end else if (ctl_we) begin
            hold_en <= wdata[dit_pkg::CTL_HOLD_BIT];
        end
    end

    // R4: advancing below the limit steps by one
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && count != limit) |=> count == $past(count) + 1'b1);

    // R4: advancing at the limit returns to zero
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expiry) |=> count == '0);

    // R5: all-ones limit gives a wrapping free-run
    p_free_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && count == '1 && limit == '1) |=> count == '0);

    // R6: frozen while halted with hold enabled
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en && halted && !cnt_we) |=> count == $past(count));

    // R10: a count write loads the written value
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we) |=> count == $past(wdata));

endmodule

// File: rtl/dit_irq_fsm.sv
module dit_irq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic arm_bit,
    input  logic expiry,
    output logic irq,
    output logic enabled
);
    import dit_pkg::*;

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (ctl_we && arm_bit) state_d = IRQ_ARMED;
            end
            IRQ_ARMED: begin
                if (ctl_we)      state_d = arm_bit ? IRQ_ARMED : IRQ_IDLE;
                else if (expiry) state_d = IRQ_FIRED;
            end
            IRQ_FIRED: begin
                if (ctl_we) state_d = arm_bit ? IRQ_ARMED : IRQ_IDLE;
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq     = (state_q == IRQ_FIRED);
        enabled = (state_q != IRQ_IDLE);
    end

    // R7: an enabled expiry without a control write raises the interrupt
    p_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_ARMED && expiry && !ctl_we) |=> irq);

    // R7: the interrupt stays up until a control write
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctl_we) |=> irq);

    // R8: any control write acknowledges
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we) |=> !irq);

    // R8: disabled timer never raises the interrupt
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !ctl_we) |=> !irq);

    // R9: a write in the same cycle as an expiry wins
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && expiry) |=> !irq);

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
    parameter int unsigned       DATA_W  = 32,
    parameter int unsigned       ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] T0_BASE = 12'h021,
    parameter logic [ADDR_W-1:0] T1_BASE = 12'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cpu_halted,
    output logic [1:0]        timer_irq
);
    import dit_pkg::*;

    localparam int unsigned NUM_TMR = 2;
    localparam int unsigned SEL_W   = NUM_TMR * REGS_PER_TMR;

    logic [DATA_W-1:0]       rd_part [NUM_TMR];
    logic [SEL_W-1:0]        sel_all;

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        localparam logic [ADDR_W-1:0] BASE = (t == 0) ? T0_BASE : T1_BASE;

        logic                    cnt_we, ctl_we, lim_we;
        logic [REGS_PER_TMR-1:0] sel;
        logic [DATA_W-1:0]       count, limit;
        logic                    hold_en, expiry, enabled, irq;
        logic [DATA_W-1:0]       ctl_view;

        dit_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
            .addr   (reg_addr),
            .we     (reg_we),
            .cnt_we (cnt_we),
            .ctl_we (ctl_we),
            .lim_we (lim_we),
            .sel    (sel)
        );

        dit_counter #(.DATA_W(DATA_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .halted  (cpu_halted),
            .cnt_we  (cnt_we),
            .ctl_we  (ctl_we),
            .lim_we  (lim_we),
            .wdata   (reg_wdata),
            .count   (count),
            .limit   (limit),
            .hold_en (hold_en),
            .expiry  (expiry)
        );

        dit_irq_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_we  (ctl_we),
            .arm_bit (reg_wdata[CTL_EN_BIT]),
            .expiry  (expiry),
            .irq     (irq),
            .enabled (enabled)
        );

        assign ctl_view = {{(DATA_W-CTL_W){1'b0}}, hold_en, enabled};

        always_comb begin
            rd_part[t] = '0;
            if (sel[0]) rd_part[t] = count;
            if (sel[1]) rd_part[t] = ctl_view;
            if (sel[2]) rd_part[t] = limit;
        end

        assign sel_all[t*REGS_PER_TMR +: REGS_PER_TMR] = sel;
        assign timer_irq[t] = irq;
    end

    always_comb begin
        reg_rdata = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            reg_rdata = reg_rdata | rd_part[t];
        end
    end

    // R2: at most one register is selected by any address
    p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_all));

    // R2: unmapped address reads zero
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_all == '0) |-> reg_rdata == '0);

endmodule

// File: tb/tb_dual_interval_timer.sv
`timescale 1ns/1ps
module tb_dual_interval_timer;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam logic [AW-1:0] A_C0 = 12'h021, A_K0 = 12'h022, A_L0 = 12'h023;
    localparam logic [AW-1:0] A_C1 = 12'h100, A_K1 = 12'h101, A_L1 = 12'h102;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          we = 1'b0;
    logic          halted = 1'b0;
    logic [DW-1:0] rdata;
    logic [1:0]    irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    dual_interval_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (addr),
        .reg_wdata  (wdata),
        .reg_we     (we),
        .reg_rdata  (rdata),
        .cpu_halted (halted),
        .timer_irq  (irq)
    );

    logic [DW-1:0] m_cnt [2];
    logic [DW-1:0] m_lim [2];
    logic          m_en  [2];
    logic          m_hold[2];
    logic          m_irq [2];

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        case (a)
            A_C0:    return m_cnt[0];
            A_K0:    return {30'b0, m_hold[0], m_en[0]};
            A_L0:    return m_lim[0];
            A_C1:    return m_cnt[1];
            A_K1:    return {30'b0, m_hold[1], m_en[1]};
            A_L1:    return m_lim[1];
            default: return '0;
        endcase
    endfunction

    task automatic model_edge(input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input logic w, input logic h);
        for (int t = 0; t < 2; t++) begin
            logic [AW-1:0] b;
            logic cw, kw, lw, adv, ex;
            b   = (t == 0) ? A_C0 : A_C1;
            cw  = w && (a == b);
            kw  = w && (a == b + 12'd1);
            lw  = w && (a == b + 12'd2);
            adv = !(m_hold[t] && h);
            ex  = adv && !cw && (m_cnt[t] == m_lim[t]);
            if (kw)                m_irq[t] = 1'b0;
            else if (ex && m_en[t]) m_irq[t] = 1'b1;
            if (cw)       m_cnt[t] = d;
            else if (adv) m_cnt[t] = (m_cnt[t] == m_lim[t]) ? '0 : m_cnt[t] + 1;
            if (lw) m_lim[t] = d;
            if (kw) begin
                m_en[t]   = d[0];
                m_hold[t] = d[1];
            end
        end
    endtask

    task automatic step(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic w, input logic h, input string tag);
        logic [DW-1:0] er;
        @(negedge clk);
        addr = a; wdata = d; we = w; halted = h;
        #1;
        er = exp_read(a);
        n_tests++;
        if (rdata !== er) begin
            n_fail++;
            $display("FAIL %s: rdata at %h actual %h expected %h", tag, a, rdata, er);
        end
        n_tests++;
        if (irq !== {m_irq[1], m_irq[0]}) begin
            n_fail++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, {m_irq[1], m_irq[0]});
        end
        @(posedge clk);
        model_edge(a, d, w, h);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        step(a, d, 1'b1, 1'b0, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic h, input string tag);
        step(a, '0, 1'b0, h, tag);
    endtask

    task automatic expect_val(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                              input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] alist [8];
        void'($urandom(32'd4711));
        alist = '{A_C0, A_K0, A_L0, A_C1, A_K1, A_L1, 12'h024, 12'h0FF};
        for (int t = 0; t < 2; t++) begin
            m_cnt[t] = '0; m_lim[t] = '0; m_en[t] = 1'b0; m_hold[t] = 1'b0; m_irq[t] = 1'b0;
        end

        // R1: values while reset is held
        repeat (2) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            addr = alist[i];
            #1;
            expect_val(rdata, '0, "R1 reset read");
        end
        expect_val({30'b0, irq}, '0, "R1 reset irq");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) rd(alist[i], 1'b0, "R1");

        // R2 / R3: map and readback widths
        wr(A_L0, 32'hA5A5_0F0F, "R3");
        rd(A_L0, 1'b0, "R3");
        expect_val(rdata, 32'hA5A5_0F0F, "R3 limit readback");
        wr(A_K1, 32'hFFFF_FFFE, "R3");
        rd(A_K1, 1'b0, "R3");
        expect_val(rdata, 32'h0000_0002, "R3 control readback");
        wr(A_K1, 32'h0, "R3");
        wr(12'h024, 32'h1234_5678, "R2 unmapped write");
        wr(12'h103, 32'h1234_5678, "R2 unmapped write");
        rd(12'h024, 1'b0, "R2");
        rd(12'h020, 1'b0, "R2");
        rd(A_L0, 1'b0, "R2 limit untouched");
        rd(A_L1, 1'b0, "R2 limit untouched");

        // R4: periodic count with limit 3
        wr(A_L0, 32'd3, "R4");
        wr(A_C0, 32'd0, "R4");
        for (int i = 0; i < 9; i++) rd(A_C0, 1'b0, "R4");

        // R5: free-running wrap
        wr(A_L1, 32'hFFFF_FFFF, "R5");
        wr(A_C1, 32'hFFFF_FFFD, "R5");
        rd(A_C1, 1'b0, "R5");
        expect_val(rdata, 32'hFFFF_FFFD, "R5 before wrap");
        rd(A_C1, 1'b0, "R5");
        rd(A_C1, 1'b0, "R5");
        rd(A_C1, 1'b0, "R5");
        expect_val(rdata, 32'h0000_0000, "R5 wrapped");
        rd(A_C1, 1'b0, "R5");

        // R6: hold while halted
        wr(A_L0, 32'd100, "R6");
        wr(A_K0, 32'd2, "R6");
        wr(A_C0, 32'd10, "R6");
        for (int i = 0; i < 4; i++) rd(A_C0, 1'b1, "R6 held");
        expect_val(rdata, 32'd10, "R6 frozen count");
        rd(A_C0, 1'b0, "R6 released");
        wr(A_K0, 32'd0, "R6");
        for (int i = 0; i < 4; i++) rd(A_C0, 1'b1, "R6 ignore halt");

        // R7 / R8: fire, stay high, acknowledge
        wr(A_L0, 32'd3, "R7");
        wr(A_K0, 32'd1, "R7");
        wr(A_C0, 32'd0, "R7");
        for (int i = 0; i < 8; i++) rd(A_K0, 1'b0, "R7 sticky");
        expect_val({31'b0, irq[0]}, 32'd1, "R7 irq high");
        wr(A_K0, 32'd1, "R8 ack rearm");
        rd(A_K0, 1'b0, "R8");
        wr(A_K0, 32'd0, "R8 ack disarm");
        for (int i = 0; i < 10; i++) rd(A_C0, 1'b0, "R8 disarmed");
        expect_val({31'b0, irq[0]}, 32'd0, "R8 stays low");

        // R9: control write collides with expiry
        wr(A_K0, 32'd1, "R9");
        wr(A_L0, 32'd20, "R9");
        wr(A_C0, 32'd20, "R9");
        wr(A_K0, 32'd1, "R9 collide");
        rd(A_C0, 1'b0, "R9 after");
        expect_val({31'b0, irq[0]}, 32'd0, "R9 write wins");

        // R10: count write at the limit is not an expiry
        wr(A_L0, 32'd5, "R10");
        wr(A_C0, 32'd5, "R10");
        wr(A_C0, 32'd2, "R10 override");
        rd(A_C0, 1'b0, "R10");
        expect_val(rdata, 32'd2, "R10 loaded");
        rd(A_C0, 1'b0, "R10");
        expect_val({31'b0, irq[0]}, 32'd0, "R10 no expiry");

        // R11: timer 1 fires, timer 0 unaffected
        wr(A_K0, 32'd0, "R11");
        wr(A_L1, 32'd2, "R11");
        wr(A_K1, 32'd1, "R11");
        wr(A_C1, 32'd0, "R11");
        for (int i = 0; i < 5; i++) rd(A_C0, 1'b0, "R11");
        expect_val({30'b0, irq}, 32'd2, "R11 only timer1 irq");

        // mixed random traffic, all requirements, model-checked each cycle
        wr(A_L0, 32'd7, "R4");
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic w, h;
            a = alist[$urandom % 8];
            w = ($urandom % 4) == 0;
            h = ($urandom % 3) == 0;
            if (a == A_K0 || a == A_K1) d = $urandom;
            else                        d = $urandom % 12;
            step(a, d, w, h, "R11 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule